// File: doc/BRIEF.md
# Pin-Change and External Interrupt Flag Unit

This block is the interrupt front end of a small 8-bit controller. It watches one dedicated external interrupt pin, a low group of eight general-purpose pins and a high group of four. Every pin first passes through a two-stage synchronizer. A change is found by comparing the synchronized level with the level one cycle earlier. Each source owns a latched flag. A per-pin mask decides which pins of a group may set that group's flag. The external pin has four sensing modes, chosen by a 2-bit field: low level, any change, falling edge and rising edge.

A source asks for service when its flag and its enable are set and the global interrupt enable input is high. Software reaches the flags, both masks and a control register through a simple select/write/read-data port. A flag clears when software writes a one to its bit. It also clears when the vector-acknowledge input names that source. If a new event arrives in the same cycle as a clear, the event wins. In low-level mode the external request follows the synchronized pin directly and its flag always reads zero. The request output names the highest-priority pending source: external first, then the low group, then the high group.

Top module: `irq_front`

## Requirements
- R1: A level change on any low-group pin whose bit is set in the low mask (select 1) sets the low-group flag, seen at flag register bit 4 three clock edges after the pin changes. A change on a pin whose mask bit is clear sets nothing.
- R2: A change on an unmasked high-group pin sets the high-group flag at flag register bit 5 with the same latency. The high mask (select 2) keeps bits 3..0 only, and its bits 7..4 read as zero.
- R3: The flag register (select 0) holds the external flag at bit 6, the high-group flag at bit 5 and the low-group flag at bit 4. All other bits read zero. After reset every register reads zero, `irq` is low and `irq_vec` is zero.
- R4: `irq` is high only when some source has a flag set (or, for the external source in low-level mode, a low synchronized pin), its enable bit is set and `gie` is high.
- R5: Asserting `vec_ack` bit k for one cycle clears the flag of source k (0 external, 1 low group, 2 high group) at that edge.
- R6: A register write to select 0 clears each flag whose bit in the written data is one. Flags whose written bit is zero keep their value.
- R7: In low-level mode (mode 00) the external flag reads zero, and the external source requests service while the synchronized pin is low. The request drops two edges after the pin goes high.
- R8: Mode 01 sets the external flag on any change, mode 10 on a falling edge only, and mode 11 on a rising edge only. Each uses the same three-edge latency as R1.
- R9: When a set event and a clear (write-one or acknowledge) hit the same flag on the same edge, the flag ends up set.
- R10: `irq_vec` is one-hot or zero. It names the highest-priority requesting source in the order external (bit 0), low group (bit 1), high group (bit 2), and `irq` equals its OR.
- R11: The control register (select 3) holds the external mode at bits 1..0 and the enables for external, high group and low group at bits 6, 5 and 4. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Dedicated external interrupt pin, asynchronous |
| pins_lo | input | 8 | Low general-purpose pin group, asynchronous |
| pins_hi | input | 4 | High general-purpose pin group, asynchronous |
| gie | input | 1 | Global interrupt enable |
| vec_ack | input | 3 | One-hot acknowledge of the serviced source |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 flags, 1 low mask, 2 high mask, 3 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 3 | One-hot index of the granted source |

## Verification
A pin change becomes visible in the flag register three edges after it is driven: two synchronizer stages, then the flag register. A level-mode request follows two edges after the pin changes. Register writes and acknowledges act on the very next edge. Read data, `irq` and `irq_vec` are combinational from the register state, so they are valid 1 ns after that edge. The bench drives and samples 1 ns after each rising edge. Its directed checks count edges exactly: they also confirm that a flag is still clear after the second edge. A cycle model that advances on the same edges checks every output on every cycle during the random phase.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;

    localparam int NSRC    = 3;
    localparam int SRC_EXT = 0;
    localparam int SRC_G0  = 1;
    localparam int SRC_G1  = 2;

    typedef enum logic [1:0] {
        EXT_LOW  = 2'b00,
        EXT_ANY  = 2'b01,
        EXT_FALL = 2'b10,
        EXT_RISE = 2'b11
    } ext_mode_e;

    typedef enum logic [1:0] {
        SEL_FLAG    = 2'd0,
        SEL_MASK_LO = 2'd1,
        SEL_MASK_HI = 2'd2,
        SEL_CTRL    = 2'd3
    } reg_sel_e;

    // bit position of each source in the flag and control registers
    function automatic logic [2:0] flag_pos(input int unsigned src);
        case (src)
            0:       flag_pos = 3'd6;
            1:       flag_pos = 3'd4;
            default: flag_pos = 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 13,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/irq_detect.sv
module irq_detect
    import irq_front_pkg::*;
#(
    parameter int N_LO = 8,
    parameter int N_HI = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_LO-1:0] lvl_lo,
    input  logic [N_HI-1:0] lvl_hi,
    input  logic            lvl_ext,
    input  logic [N_LO-1:0] mask_lo,
    input  logic [N_HI-1:0] mask_hi,
    input  ext_mode_e       mode,
    output logic [NSRC-1:0] evt
);

    typedef struct packed {
        logic [N_LO-1:0] lo;
        logic [N_HI-1:0] hi;
        logic            ext;
    } prev_t;

    prev_t           prev_d, prev_q;
    logic [N_LO-1:0] chg_lo;
    logic [N_HI-1:0] chg_hi;

    always_comb begin
        prev_d.lo  = lvl_lo;
        prev_d.hi  = lvl_hi;
        prev_d.ext = lvl_ext;

        chg_lo = lvl_lo ^ prev_q.lo;
        chg_hi = lvl_hi ^ prev_q.hi;

        evt          = '0;
        evt[SRC_G0]  = |(chg_lo & mask_lo);
        evt[SRC_G1]  = |(chg_hi & mask_hi);
        case (mode)
            EXT_ANY:  evt[SRC_EXT] = lvl_ext ^ prev_q.ext;
            EXT_FALL: evt[SRC_EXT] = prev_q.ext & ~lvl_ext;
            EXT_RISE: evt[SRC_EXT] = ~prev_q.ext & lvl_ext;
            default:  evt[SRC_EXT] = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assert_masked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_lo == '0) |-> !evt[SRC_G0]);
    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_hi == '0) |-> !evt[SRC_G1]);
    assert_level_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EXT_LOW) |-> !evt[SRC_EXT]);
    assert_fall_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EXT_FALL && evt[SRC_EXT]) |-> (!lvl_ext && $past(lvl_ext)));
    assert_rise_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EXT_RISE && evt[SRC_EXT]) |-> (lvl_ext && !$past(lvl_ext)));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_front_pkg::*;
#(
    parameter int N_LO = 8,
    parameter int N_HI = 4,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] ack,
    input  logic            reg_we,
    input  logic [1:0]      reg_sel,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [N_LO-1:0] mask_lo,
    output logic [N_HI-1:0] mask_hi,
    output ext_mode_e       mode,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] flag
);

    typedef struct packed {
        logic [N_LO-1:0] mask_lo;
        logic [N_HI-1:0] mask_hi;
        ext_mode_e       mode;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flag;
    } state_t;

    state_t          st_d, st_q;
    logic [NSRC-1:0] clr;
    logic            flag_wr;

    always_comb begin
        st_d    = st_q;
        flag_wr = reg_we && (reg_sel_e'(reg_sel) == SEL_FLAG);

        if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                SEL_MASK_LO: st_d.mask_lo = reg_wdata[N_LO-1:0];
                SEL_MASK_HI: st_d.mask_hi = reg_wdata[N_HI-1:0];
                SEL_CTRL: begin
                    st_d.mode = ext_mode_e'(reg_wdata[1:0]);
                    for (int i = 0; i < NSRC; i++) begin
                        st_d.en[i] = reg_wdata[flag_pos(i)];
                    end
                end
                default: ;
            endcase
        end

        // a fresh event outranks a clear on the same edge
        for (int i = 0; i < NSRC; i++) begin
            clr[i]       = ack[i] | (flag_wr & reg_wdata[flag_pos(i)]);
            st_d.flag[i] = evt[i] | (st_q.flag[i] & ~clr[i]);
        end
        if (st_q.mode == EXT_LOW) st_d.flag[SRC_EXT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_sel))
            SEL_FLAG: begin
                for (int i = 0; i < NSRC; i++) begin
                    reg_rdata[flag_pos(i)] = st_q.flag[i];
                end
                if (st_q.mode == EXT_LOW) reg_rdata[flag_pos(SRC_EXT)] = 1'b0;
            end
            SEL_MASK_LO: reg_rdata[N_LO-1:0] = st_q.mask_lo;
            SEL_MASK_HI: reg_rdata[N_HI-1:0] = st_q.mask_hi;
            default: begin
                reg_rdata[1:0] = st_q.mode;
                for (int i = 0; i < NSRC; i++) begin
                    reg_rdata[flag_pos(i)] = st_q.en[i];
                end
            end
        endcase
    end

    assign mask_lo = st_q.mask_lo;
    assign mask_hi = st_q.mask_hi;
    assign mode    = st_q.mode;
    assign en      = st_q.en;
    assign flag    = st_q.flag;

    generate
        for (genvar g = 1; g < NSRC; g++) begin : g_chk
            assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
                evt[g] |=> st_q.flag[g]);
            assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (ack[g] && !evt[g]) |=> !st_q.flag[g]);
            assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_wr && reg_wdata[flag_pos(g)] && !evt[g]) |=> !st_q.flag[g]);
        end
    endgenerate

    assert_level_flag_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == EXT_LOW && $past(st_q.mode == EXT_LOW)) |-> !st_q.flag[SRC_EXT]);

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    input  logic         gie,
    output logic         irq,
    output logic [N-1:0] vec
);

    logic found;

    always_comb begin
        vec   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (gie && pend[i] && !found) begin
                vec[i] = 1'b1;
                found  = 1'b1;
            end
        end
        irq = found;
    end

    assert_vec_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec));
    assert_needs_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie);
    assert_top_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && pend[0]) |-> vec[0]);
    assert_irq_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ($countones(vec) == 1));

endmodule

// File: rtl/irq_front.sv
module irq_front
    import irq_front_pkg::*;
#(
    parameter int N_LO        = 8,
    parameter int N_HI        = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_pin,
    input  logic [N_LO-1:0] pins_lo,
    input  logic [N_HI-1:0] pins_hi,
    input  logic            gie,
    input  logic [NSRC-1:0] vec_ack,
    input  logic            reg_we,
    input  logic [1:0]      reg_sel,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq,
    output logic [NSRC-1:0] irq_vec
);

    localparam int NPIN = N_LO + N_HI + 1;

    logic [NPIN-1:0] pins_raw, pins_s;
    logic [N_LO-1:0] mask_lo;
    logic [N_HI-1:0] mask_hi;
    ext_mode_e       mode;
    logic [NSRC-1:0] evt, en, flag, pend;

    assign pins_raw = {ext_pin, pins_hi, pins_lo};

    irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    irq_detect #(.N_LO(N_LO), .N_HI(N_HI)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_lo (pins_s[N_LO-1:0]),
        .lvl_hi (pins_s[N_LO +: N_HI]),
        .lvl_ext(pins_s[NPIN-1]),
        .mask_lo(mask_lo),
        .mask_hi(mask_hi),
        .mode   (mode),
        .evt    (evt)
    );

    irq_regs #(.N_LO(N_LO), .N_HI(N_HI), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .ack      (vec_ack),
        .reg_we   (reg_we),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mask_lo  (mask_lo),
        .mask_hi  (mask_hi),
        .mode     (mode),
        .en       (en),
        .flag     (flag)
    );

    always_comb begin
        pend = flag & en;
        if (mode == EXT_LOW) pend[SRC_EXT] = ~pins_s[NPIN-1] & en[SRC_EXT];
    end

    irq_prio #(.N(NSRC)) u_prio (
        .clk  (clk),
        .rst_n(rst_n),
        .pend (pend),
        .gie  (gie),
        .irq  (irq),
        .vec  (irq_vec)
    );

    assert_level_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EXT_LOW && gie && en[SRC_EXT] && !pins_s[NPIN-1]) |-> (irq && irq_vec[SRC_EXT]));

endmodule

// File: tb/irq_front_bench.sv
`timescale 1ns/1ps
module irq_front_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b1;
    logic [7:0] pins_lo = '0;
    logic [3:0] pins_hi = '0;
    logic       gie = 1'b0;
    logic [2:0] vec_ack = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic [2:0] irq_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_front u_irq_front (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pins_lo(pins_lo),
        .pins_hi(pins_hi), .gie(gie), .vec_ack(vec_ack), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .irq_vec(irq_vec)
    );

    always #2 clk = ~clk;

    // ---------------- cycle model built from the requirements ----------------
    logic [12:0] m_s1, m_s2, m_prev;
    logic [7:0]  m_mask_lo;
    logic [3:0]  m_mask_hi;
    logic [1:0]  m_mode;
    logic [2:0]  m_en, m_flag;
    logic [12:0] m_chg;
    logic [2:0]  m_set, m_clr, m_nf;

    function automatic int posn(input int s);
        return (s == 0) ? 6 : (s == 1) ? 4 : 5;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
            m_mask_lo <= '0; m_mask_hi <= '0; m_mode <= '0; m_en <= '0; m_flag <= '0;
        end else begin
            m_chg = m_s2 ^ m_prev;
            m_set[1] = |(m_chg[7:0] & m_mask_lo);
            m_set[2] = |(m_chg[11:8] & m_mask_hi);
            case (m_mode)
                2'b01:   m_set[0] = m_chg[12];
                2'b10:   m_set[0] = m_prev[12] & ~m_s2[12];
                2'b11:   m_set[0] = ~m_prev[12] & m_s2[12];
                default: m_set[0] = 1'b0;
            endcase
            for (int s = 0; s < 3; s++) begin
                m_clr[s] = vec_ack[s] | (reg_we && reg_sel == 2'd0 && reg_wdata[posn(s)]);
                m_nf[s]  = m_set[s] | (m_flag[s] & ~m_clr[s]);
            end
            if (m_mode == 2'b00) m_nf[0] = 1'b0;
            m_flag <= m_nf;
            m_s1   <= {ext_pin, pins_hi, pins_lo};
            m_s2   <= m_s1;
            m_prev <= m_s2;
            if (reg_we) begin
                case (reg_sel)
                    2'd1: m_mask_lo <= reg_wdata;
                    2'd2: m_mask_hi <= reg_wdata[3:0];
                    2'd3: begin
                        m_mode <= reg_wdata[1:0];
                        m_en   <= {reg_wdata[5], reg_wdata[4], reg_wdata[6]};
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_rdata();
        logic [7:0] r = '0;
        case (reg_sel)
            2'd0: begin
                r[6] = (m_mode == 2'b00) ? 1'b0 : m_flag[0];
                r[5] = m_flag[2];
                r[4] = m_flag[1];
            end
            2'd1: r = m_mask_lo;
            2'd2: r = {4'b0, m_mask_hi};
            default: r = {1'b0, m_en[0], m_en[2], m_en[1], 2'b00, m_mode};
        endcase
        return r;
    endfunction

    function automatic logic [2:0] exp_vec();
        logic [2:0] p;
        p    = m_flag & m_en;
        if (m_mode == 2'b00) p[0] = ~m_s2[12] & m_en[0];
        if (!gie) return 3'b000;
        if (p[0]) return 3'b001;
        if (p[1]) return 3'b010;
        if (p[2]) return 3'b100;
        return 3'b000;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (rst_n) begin
            chk(reg_rdata === exp_rdata(), "R3 model read data", reg_rdata, exp_rdata());
            chk(irq === (exp_vec() != 0), "R4 model irq", {7'b0, irq}, {7'b0, exp_vec() != 0});
            chk(irq_vec === exp_vec(), "R10 model vector", {5'b0, irq_vec}, {5'b0, exp_vec()});
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] data);
        reg_sel = sel;
        #0.5;
        data = reg_rdata;
    endtask

    task automatic expect_rd(input logic [1:0] sel, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(sel, v);
        chk(v === exp, req, v, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [12:0] p;
        void'($urandom(32'd20240611));
        steps(3);
        rst_n = 1'b1;
        // R3 R11 R2: reset values
        expect_rd(2'd0, 8'h00, "R3 flags after reset");
        expect_rd(2'd1, 8'h00, "R1 low mask after reset");
        expect_rd(2'd2, 8'h00, "R2 high mask after reset");
        expect_rd(2'd3, 8'h00, "R11 control after reset");
        chk(irq === 1'b0 && irq_vec === 3'b000, "R3 no request after reset", {4'b0, irq, irq_vec}, 8'h00);
        steps(4);

        gie = 1'b1;
        wr(2'd1, 8'h08);
        wr(2'd3, 8'h71);                 // any-change mode, all enables
        expect_rd(2'd3, 8'h71, "R11 control readback");

        // R1: three-edge latency on an unmasked low pin
        pins_lo[3] = 1'b1;
        steps(2);
        expect_rd(2'd0, 8'h00, "R1 flag not yet set after two edges");
        step();
        expect_rd(2'd0, 8'h10, "R1 low group flag at third edge");
        chk(irq === 1'b1 && irq_vec === 3'b010, "R10 low group request", {5'b0, irq_vec}, 8'h02);

        // R6: zeros leave flags alone, ones clear
        wr(2'd0, 8'hEF);
        expect_rd(2'd0, 8'h10, "R6 write of zero keeps flag");
        wr(2'd0, 8'h10);
        expect_rd(2'd0, 8'h00, "R6 write of one clears flag");

        // R1: masked pin does nothing
        pins_lo[0] = 1'b1;
        steps(4);
        expect_rd(2'd0, 8'h00, "R1 masked pin ignored");

        // R5: acknowledge clears
        pins_lo[3] = 1'b0;
        steps(3);
        expect_rd(2'd0, 8'h10, "R1 falling change also sets");
        vec_ack = 3'b010;
        step();
        vec_ack = 3'b000;
        expect_rd(2'd0, 8'h00, "R5 acknowledge clears low group flag");

        // R2: high group
        wr(2'd2, 8'hFF);
        expect_rd(2'd2, 8'h0F, "R2 high mask upper bits zero");
        pins_hi[2] = 1'b1;
        steps(3);
        expect_rd(2'd0, 8'h20, "R2 high group flag");
        chk(irq_vec === 3'b100, "R10 high group alone", {5'b0, irq_vec}, 8'h04);

        // R10 priority, R8 any change
        pins_lo[3] = 1'b1;
        steps(3);
        chk(irq_vec === 3'b010, "R10 low group beats high group", {5'b0, irq_vec}, 8'h02);
        ext_pin = 1'b0;
        steps(3);
        expect_rd(2'd0, 8'h70, "R8 any-change sets external flag");
        chk(irq_vec === 3'b001, "R10 external first", {5'b0, irq_vec}, 8'h01);

        // R4: global enable gates
        gie = 1'b0;
        #0.5;
        chk(irq === 1'b0 && irq_vec === 3'b000, "R4 global enable off", {4'b0, irq, irq_vec}, 8'h00);
        gie = 1'b1;
        wr(2'd0, 8'h70);
        expect_rd(2'd0, 8'h00, "R6 clear all flags");

        // R7: level mode
        wr(2'd3, 8'h70);
        expect_rd(2'd0, 8'h00, "R7 flag reads zero in level mode");
        chk(irq === 1'b1 && irq_vec === 3'b001, "R7 low level requests", {4'b0, irq, irq_vec}, 8'h09);
        ext_pin = 1'b1;
        step();
        chk(irq === 1'b1, "R7 request held one edge", {7'b0, irq}, 8'h01);
        step();
        chk(irq === 1'b0, "R7 request drops after two edges", {7'b0, irq}, 8'h00);

        // R8: falling-edge mode
        wr(2'd3, 8'h72);
        ext_pin = 1'b0;
        steps(3);
        expect_rd(2'd0, 8'h40, "R8 falling edge sets");
        wr(2'd0, 8'h40);
        ext_pin = 1'b1;
        steps(3);
        expect_rd(2'd0, 8'h00, "R8 rising edge ignored in falling mode");

        // R8: rising-edge mode
        wr(2'd3, 8'h73);
        ext_pin = 1'b0;
        steps(3);
        expect_rd(2'd0, 8'h00, "R8 falling edge ignored in rising mode");
        ext_pin = 1'b1;
        steps(3);
        expect_rd(2'd0, 8'h40, "R8 rising edge sets");
        wr(2'd0, 8'h40);

        // R9: set and clear on the same edge
        pins_lo[3] = 1'b0;
        steps(3);
        pins_lo[3] = 1'b1;
        steps(2);
        wr(2'd0, 8'h10);
        expect_rd(2'd0, 8'h10, "R9 set wins over write-one clear");
        wr(2'd0, 8'h10);
        expect_rd(2'd0, 8'h00, "R9 later clear takes effect");
        pins_lo[3] = 1'b0;
        steps(2);
        vec_ack = 3'b010;
        step();
        vec_ack = 3'b000;
        expect_rd(2'd0, 8'h10, "R9 set wins over acknowledge");

        wr(2'd3, 8'hFF);
        expect_rd(2'd3, 8'h73, "R11 reserved control bits read zero");

        // random phase, checked by the cycle model every cycle
        for (int c = 0; c < 3000; c++) begin
            p = {ext_pin, pins_hi, pins_lo};
            if ($urandom % 3 == 0) p[$urandom % 13] ^= 1'b1;
            {ext_pin, pins_hi, pins_lo} = p;
            vec_ack = ($urandom % 4 == 0) ? (3'b001 << ($urandom % 3)) : 3'b000;
            reg_we  = ($urandom % 6 == 0);
            reg_sel = 2'($urandom);
            if (reg_we && reg_sel == 2'd3 && ($urandom % 4 != 0)) reg_we = 1'b0;
            reg_wdata = 8'($urandom);
            if ($urandom % 50 == 0) gie = ~gie;
            step();
        end
        reg_we = 1'b0;
        vec_ack = '0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule